// File: doc/BRIEF.md
# Two-Stage Watchdog Timer

This block is a watchdog with a small register port. A slow reference tick, 32 000 pulses per second, arrives as a one-cycle enable. It passes through a power-of-two prescaler and then decrements a 16-bit countdown. When the countdown runs out, the block raises a configurable event: an interrupt, a system-management interrupt (SMI), or a system reset. The countdown then reloads and keeps running.

The first expiry uses the first event type and sets a sticky overflow flag. Any expiry that follows while overflow is still set uses the second event type. Software services the watchdog by rewriting the timeout, which reloads the count and restarts the prescaler. A timeout of zero disables the watchdog.

Sticky indicator flags record which events have fired. The overflow flag and the three indicators are cleared by two different write rules, so software can acknowledge the escalation stage and the event indications separately. The longest interval is 2^13 × 65535 / 32000 seconds.

Top module: `wdt_two_stage`

## Requirements
- R1: After reset, the three registers read 0 and wd_irq, wd_smi and wd_rst_pulse are low.
- R2: The register map is as follows. The timeout register (16 bits) is at address 0x0. The configuration register (16 bits) is at 0x2. The status register is at 0x4, uses 8 bits, and reads 0 in bits [15:8]. Configuration bits [15:9] and status bits [7:4] read back the value last written and have no effect.
- R3: The count decrements once every 2^P accepted ticks, where P is configuration bits [3:0]. Codes 0xE and 0xF are stored as written but behave as 0xD.
- R4: With timeout T written, expiry happens on the T-th prescaled decrement. The counter then reloads T.
- R5: A timeout of 0 never expires.
- R6: While configuration bit 8 is 1, ticks are ignored and counting halts. Counting resumes when the bit is 0.
- R7: An expiry with overflow (status bit 0) clear fires event type 1 and sets overflow. Event type 1 is configuration bits [5:4], where 00 is none, 01 is interrupt, 10 is SMI and 11 is reset.
- R8: An expiry with overflow already set fires event type 2, which is configuration bits [7:6] with the same encoding. Overflow stays set.
- R9: An interrupt event sets status bit 1. An SMI event sets status bit 2. wd_irq and wd_smi follow these bits as levels until the bits are cleared.
- R10: A reset event sets status bit 3 and drives wd_rst_pulse high for exactly one cycle.
- R11: A status write with bit 0 = 1 clears overflow and leaves bits [3:1] unchanged.
- R12: A status write with bit 0 = 0 clears bits [3:1] and leaves overflow unchanged.
- R13: Writing the timeout register reloads the count and restarts the prescaler phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high power-on reset |
| tick_en | input | 1 | One-cycle pulse per slow reference tick |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register byte address |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data (combinational from reg_addr) |
| wd_irq | output | 1 | Interrupt level |
| wd_smi | output | 1 | System-management interrupt level |
| wd_rst_pulse | output | 1 | One-cycle system reset request |

## Verification
The assertions assume the following about the inputs:
- reg_wr is a single-cycle strobe with a stable address and data.
- tick_en carries no meaning while a timeout write lands in the same cycle. A timeout write takes priority over a tick.

The stimulus follows these rules:
- It drives every input on the falling edge.
- It issues one register write at a time.
- It separates ticks by at least one idle cycle.
- It never lands a status write in the cycle of an expiry.

Under these rules the set-wins ordering between an event and a clear is never relied upon.

// File: rtl/wdt_pkg.sv
package wdt_pkg;

    localparam int CNT_W      = 16;
    localparam int CODE_MAX   = 13;
    localparam int REG_W      = 16;
    localparam int ADDR_W     = 3;

    localparam logic [ADDR_W-1:0] ADDR_TMO = 3'h0;
    localparam logic [ADDR_W-1:0] ADDR_CFG = 3'h2;
    localparam logic [ADDR_W-1:0] ADDR_STS = 3'h4;

    typedef enum logic [1:0] {
        EV_NONE  = 2'b00,
        EV_IRQ   = 2'b01,
        EV_SMI   = 2'b10,
        EV_RESET = 2'b11
    } wd_event_e;

    typedef struct packed {
        logic [6:0] spare;
        logic       gate;
        wd_event_e  second;
        wd_event_e  first;
        logic [3:0] presc;
    } wd_cfg_t;

    typedef struct packed {
        logic [3:0] spare;
        logic       rst_seen;
        logic       smi_seen;
        logic       irq_seen;
        logic       expired;
    } wd_status_t;

    function automatic logic [3:0] clamp_code(input logic [3:0] code, input int max_code);
        return (int'(code) > max_code) ? 4'(max_code) : code;
    endfunction

endpackage

// File: rtl/wdt_prescaler.sv
module wdt_prescaler #(
    parameter int MAX_CODE = wdt_pkg::CODE_MAX
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       tick_en,
    input  logic       run,
    input  logic       restart,
    input  logic [3:0] code,
    output logic       slow_tick
);
    localparam int PW = MAX_CODE;

    logic [PW-1:0] acc;
    logic [PW:0]   one_hot;
    logic [PW-1:0] mask;
    logic [3:0]    eff;

    always_comb begin
        eff     = wdt_pkg::clamp_code(code, MAX_CODE);
        one_hot = (PW+1)'(1) << eff;
        mask    = PW'(one_hot - (PW+1)'(1));
    end

    assign slow_tick = run && tick_en && (acc >= mask);

    always_ff @(posedge clk) begin
        if (rst || restart) begin
            acc <= '0;
        end else if (run && tick_en) begin
            acc <= slow_tick ? '0 : acc + PW'(1);
        end
    end
endmodule

// File: rtl/wdt_counter.sv
module wdt_counter #(
    parameter int CNT_W = wdt_pkg::CNT_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic [CNT_W-1:0] reload_val,
    input  logic             slow_tick,
    output logic             expire,
    output logic [CNT_W-1:0] count
);
    assign expire = slow_tick && !load && (count == CNT_W'(1));

    always_ff @(posedge clk) begin
        if (rst) begin
            count <= '0;
        end else if (load) begin
            count <= load_val;
        end else if (expire) begin
            count <= reload_val;
        end else if (slow_tick && count != '0) begin
            count <= count - CNT_W'(1);
        end
    end
endmodule

// File: rtl/wdt_regs.sv
module wdt_regs
    import wdt_pkg::*;
#(
    parameter int CNT_W  = wdt_pkg::CNT_W,
    parameter int ADDR_W = wdt_pkg::ADDR_W,
    parameter int REG_W  = wdt_pkg::REG_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [REG_W-1:0]  wdata,
    input  logic              expire,
    output logic [CNT_W-1:0]  tmo_q,
    output logic              tmo_wr,
    output logic              sts_wr,
    output wd_cfg_t           cfg_q,
    output wd_status_t        sts_q,
    output logic              rst_pulse,
    output logic [REG_W-1:0]  rdata
);
    localparam int STS_W = $bits(wd_status_t);

    logic       cfg_wr;
    wd_event_e  ev;
    wd_status_t sts_d;

    assign tmo_wr = wr_en && (addr == ADDR_TMO);
    assign cfg_wr = wr_en && (addr == ADDR_CFG);
    assign sts_wr = wr_en && (addr == ADDR_STS);
    assign ev     = sts_q.expired ? cfg_q.second : cfg_q.first;

    always_comb begin
        sts_d = sts_q;
        if (sts_wr) begin
            sts_d.spare = wdata[7:4];
            if (wdata[0]) begin
                sts_d.expired = 1'b0;
            end else begin
                sts_d.rst_seen = 1'b0;
                sts_d.smi_seen = 1'b0;
                sts_d.irq_seen = 1'b0;
            end
        end
        if (expire) begin
            sts_d.expired = 1'b1;
            unique case (ev)
                EV_IRQ:   sts_d.irq_seen = 1'b1;
                EV_SMI:   sts_d.smi_seen = 1'b1;
                EV_RESET: sts_d.rst_seen = 1'b1;
                default:  ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            tmo_q     <= '0;
            cfg_q     <= '0;
            sts_q     <= '0;
            rst_pulse <= 1'b0;
        end else begin
            if (tmo_wr) tmo_q <= CNT_W'(wdata);
            if (cfg_wr) cfg_q <= wd_cfg_t'(wdata);
            sts_q     <= sts_d;
            rst_pulse <= expire && (ev == EV_RESET);
        end
    end

    always_comb begin
        unique case (addr)
            ADDR_TMO: rdata = REG_W'(tmo_q);
            ADDR_CFG: rdata = REG_W'(cfg_q);
            ADDR_STS: rdata = {{(REG_W-STS_W){1'b0}}, sts_q};
            default:  rdata = '0;
        endcase
    end
endmodule

// File: rtl/wdt_two_stage.sv
module wdt_two_stage
    import wdt_pkg::*;
#(
    parameter int CNT_W    = wdt_pkg::CNT_W,
    parameter int MAX_CODE = wdt_pkg::CODE_MAX
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        tick_en,
    input  logic        reg_wr,
    input  logic [2:0]  reg_addr,
    input  logic [15:0] reg_wdata,
    output logic [15:0] reg_rdata,
    output logic        wd_irq,
    output logic        wd_smi,
    output logic        wd_rst_pulse
);
    logic             tmo_wr;
    logic             sts_wr;
    logic             slow_tick;
    logic             expire;
    logic [CNT_W-1:0] tmo_q;
    logic [CNT_W-1:0] count;
    wd_cfg_t          cfg_q;
    wd_status_t       sts_q;

    wdt_regs #(.CNT_W(CNT_W)) u_regs (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (reg_wr),
        .addr      (reg_addr),
        .wdata     (reg_wdata),
        .expire    (expire),
        .tmo_q     (tmo_q),
        .tmo_wr    (tmo_wr),
        .sts_wr    (sts_wr),
        .cfg_q     (cfg_q),
        .sts_q     (sts_q),
        .rst_pulse (wd_rst_pulse),
        .rdata     (reg_rdata)
    );

    wdt_prescaler #(.MAX_CODE(MAX_CODE)) u_presc (
        .clk       (clk),
        .rst       (rst),
        .tick_en   (tick_en),
        .run       (!cfg_q.gate),
        .restart   (tmo_wr),
        .code      (cfg_q.presc),
        .slow_tick (slow_tick)
    );

    wdt_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk        (clk),
        .rst        (rst),
        .load       (tmo_wr),
        .load_val   (CNT_W'(reg_wdata)),
        .reload_val (tmo_q),
        .slow_tick  (slow_tick),
        .expire     (expire),
        .count      (count)
    );

    assign wd_irq = sts_q.irq_seen;
    assign wd_smi = sts_q.smi_seen;
endmodule

// File: rtl/wdt_checker.sv
module wdt_checker
    import wdt_pkg::*;
#(
    parameter int CNT_W = wdt_pkg::CNT_W
) (
    input logic             clk,
    input logic             rst,
    input logic             expire,
    input logic [CNT_W-1:0] count,
    input logic             tmo_wr,
    input logic             sts_wr,
    input logic             wbit0,
    input wd_cfg_t          cfg_q,
    input wd_status_t       sts_q,
    input logic             wd_irq,
    input logic             wd_smi,
    input logic             wd_rst_pulse
);
    p_expire_at_one_r4: assert property (@(posedge clk) disable iff (rst)
        expire |-> count == CNT_W'(1));

    p_gate_freeze_r6: assert property (@(posedge clk) disable iff (rst)
        (cfg_q.gate && !tmo_wr) |=> $stable(count));

    p_ovf_cause_r7: assert property (@(posedge clk) disable iff (rst)
        $rose(sts_q.expired) |-> $past(expire));

    p_irq_cause_r9: assert property (@(posedge clk) disable iff (rst)
        $rose(wd_irq) |-> $past(expire));

    p_pulse_flag_r10: assert property (@(posedge clk) disable iff (rst)
        wd_rst_pulse |-> sts_q.rst_seen);

    p_ovf_clear_r11: assert property (@(posedge clk) disable iff (rst)
        $fell(sts_q.expired) |-> $past(sts_wr && wbit0));

    p_smi_clear_r12: assert property (@(posedge clk) disable iff (rst)
        $fell(wd_smi) |-> $past(sts_wr && !wbit0));
endmodule

bind wdt_two_stage wdt_checker #(.CNT_W(CNT_W)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .expire       (expire),
    .count        (count),
    .tmo_wr       (tmo_wr),
    .sts_wr       (sts_wr),
    .wbit0        (reg_wdata[0]),
    .cfg_q        (cfg_q),
    .sts_q        (sts_q),
    .wd_irq       (wd_irq),
    .wd_smi       (wd_smi),
    .wd_rst_pulse (wd_rst_pulse)
);

// File: tb/tb_wdt_two_stage.sv
module tb_wdt_two_stage;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        tick_en = 1'b0;
    logic        reg_wr = 1'b0;
    logic [2:0]  reg_addr = 3'h0;
    logic [15:0] reg_wdata = 16'h0;
    logic [15:0] reg_rdata;
    logic        wd_irq, wd_smi, wd_rst_pulse;

    int n_tests = 0;
    int n_fail  = 0;
    int cycles  = 0;

    always #10 clk = ~clk;

    wdt_two_stage dut (
        .clk(clk), .rst(rst), .tick_en(tick_en), .reg_wr(reg_wr),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .wd_irq(wd_irq), .wd_smi(wd_smi), .wd_rst_pulse(wd_rst_pulse)
    );

    // behavioural reference model
    int m_tmo, m_cfg, m_cnt, m_pc, m_rsv;
    bit m_ovf, m_int, m_smi, m_rstf, m_pulse;

    always @(posedge clk) begin
        int code, div, sel;
        bit fire;
        if (rst) begin
            m_tmo = 0; m_cfg = 0; m_cnt = 0; m_pc = 0; m_rsv = 0;
            m_ovf = 0; m_int = 0; m_smi = 0; m_rstf = 0; m_pulse = 0;
        end else begin
            code = m_cfg % 16;
            if (code > 13) code = 13;
            div  = 1 << code;
            fire = 0;
            if (reg_wr && reg_addr == 3'h0) begin
                m_cnt = reg_wdata; m_pc = 0;
            end else if (((m_cfg >> 8) % 2) == 0 && tick_en) begin
                if (m_pc + 1 >= div) begin
                    m_pc = 0;
                    if (m_cnt == 1) begin fire = 1; m_cnt = m_tmo; end
                    else if (m_cnt > 1) m_cnt = m_cnt - 1;
                end else m_pc = m_pc + 1;
            end
            sel = m_ovf ? (m_cfg >> 6) % 4 : (m_cfg >> 4) % 4;
            if (reg_wr && reg_addr == 3'h0) m_tmo = reg_wdata;
            if (reg_wr && reg_addr == 3'h2) m_cfg = reg_wdata;
            if (reg_wr && reg_addr == 3'h4) begin
                m_rsv = reg_wdata[7:4];
                if (reg_wdata[0]) m_ovf = 0;
                else begin m_int = 0; m_smi = 0; m_rstf = 0; end
            end
            m_pulse = fire && sel == 3;
            if (fire) begin
                m_ovf = 1;
                if (sel == 1) m_int = 1;
                if (sel == 2) m_smi = 1;
                if (sel == 3) m_rstf = 1;
            end
        end
    end

    task automatic check(input logic [15:0] act, input logic [15:0] exp, input string tag);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // per-cycle comparison against the model (R9, R10)
    always @(negedge clk) begin
        if (!rst) begin
            check({15'h0, wd_irq}, {15'h0, m_int}, "R9 irq vs model");
            check({15'h0, wd_smi}, {15'h0, m_smi}, "R9 smi vs model");
            check({15'h0, wd_rst_pulse}, {15'h0, m_pulse}, "R10 pulse vs model");
        end
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 190000) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    task automatic wr(input logic [2:0] a, input logic [15:0] d);
        @(negedge clk); reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk); reg_wr = 1'b0;
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); tick_en = 1'b1;
            @(negedge clk); tick_en = 1'b0;
        end
    endtask

    task automatic rd(input logic [2:0] a, input logic [15:0] exp, input string tag);
        reg_addr = a; #1;
        check(reg_rdata, exp, tag);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        rd(3'h0, 16'h0000, "R1 timeout reset");
        rd(3'h2, 16'h0000, "R1 config reset");
        rd(3'h4, 16'h0000, "R1 status reset");
        check({13'h0, wd_irq, wd_smi, wd_rst_pulse}, 16'h0, "R1 outputs reset");

        // R2 reserved bits read back
        wr(3'h2, 16'hFE00);
        rd(3'h2, 16'hFE00, "R2 config spare readback");
        wr(3'h4, 16'h00F1);
        rd(3'h4, 16'h00F0, "R2 status spare readback");

        // R5 zero timeout never expires
        wr(3'h2, 16'hFE10);
        ticks(20);
        check({15'h0, wd_irq}, 16'h0, "R5 zero timeout no irq");
        rd(3'h4, 16'h00F0, "R5 status unchanged");

        // R3/R4/R7: code 2 (divide by 4), type1 irq, type2 smi, T=3
        wr(3'h2, 16'hFE92);
        wr(3'h0, 16'h0003);
        rd(3'h0, 16'h0003, "R2 timeout readback");
        ticks(11);
        check({15'h0, wd_irq}, 16'h0, "R3 R4 no irq before 12 ticks");
        ticks(1);
        check({15'h0, wd_irq}, 16'h1, "R4 R7 irq on 12th tick");
        rd(3'h4, 16'h00F3, "R7 overflow and irq flag");

        // R8 second expiry uses type2, R9 irq still held
        ticks(11);
        check({15'h0, wd_smi}, 16'h0, "R8 no smi early");
        ticks(1);
        check({15'h0, wd_smi}, 16'h1, "R8 smi on second expiry");
        check({15'h0, wd_irq}, 16'h1, "R9 irq level held");
        rd(3'h4, 16'h00F7, "R8 status after second expiry");

        // R12 clear indicators
        wr(3'h4, 16'h00F0);
        rd(3'h4, 16'h00F1, "R12 indicators cleared, overflow kept");
        check({14'h0, wd_irq, wd_smi}, 16'h0, "R12 levels dropped");
        // R11 clear overflow
        wr(3'h4, 16'h00F1);
        rd(3'h4, 16'h00F0, "R11 overflow cleared");

        // R3 reserved code 0xF acts as 0xD, R10 reset event
        wr(3'h2, 16'hFE3F);
        wr(3'h0, 16'h0001);
        rd(3'h2, 16'hFE3F, "R3 reserved code stored");
        ticks(8191);
        check({15'h0, wd_rst_pulse}, 16'h0, "R3 no expiry before 8192 ticks");
        rd(3'h4, 16'h00F0, "R3 status before expiry");
        ticks(1);
        check({15'h0, wd_rst_pulse}, 16'h1, "R10 reset pulse high");
        @(negedge clk);
        check({15'h0, wd_rst_pulse}, 16'h0, "R10 reset pulse one cycle");
        rd(3'h4, 16'h00F9, "R10 reset flag and overflow");

        // R6 gate halts counting
        wr(3'h4, 16'h00F0);
        wr(3'h4, 16'h00F1);
        rd(3'h4, 16'h00F0, "R11 R12 status cleared");
        wr(3'h2, 16'hFF10);
        wr(3'h0, 16'h0002);
        ticks(10);
        check({15'h0, wd_irq}, 16'h0, "R6 gated no irq");
        wr(3'h2, 16'hFE10);
        ticks(1);
        check({15'h0, wd_irq}, 16'h0, "R6 one tick after ungate");
        ticks(1);
        check({15'h0, wd_irq}, 16'h1, "R6 irq after ungate");

        // R13 timeout write restarts prescaler and count
        wr(3'h4, 16'h00F0);
        wr(3'h4, 16'h00F1);
        wr(3'h2, 16'hFE11);
        wr(3'h0, 16'h0004);
        ticks(7);
        check({15'h0, wd_irq}, 16'h0, "R13 before service");
        wr(3'h0, 16'h0004);
        ticks(7);
        check({15'h0, wd_irq}, 16'h0, "R13 restarted phase");
        ticks(1);
        check({15'h0, wd_irq}, 16'h1, "R13 expiry after full interval");

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule